// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block picks the control-store row that a microprogrammed controller reads on each cycle. It takes the 8-bit opcode held in the instruction register and a 2-bit next-source field from the current control word. The field is captured in a small register, and that register steers a four-way address multiplexer. The sources are an opcode mapping function, the low bits of the raw instruction register, a fixed shared row, and the row already in use.

The mapping function is not a one-to-one table. A run of two-byte instructions that behave the same way in their first cycle all land on one shared row. Instructions that share their second cycle instead jump to the fixed row at the top of the control store. Both choices keep the control store small. The halt opcode is marked in the mapping output, and a hold selection then keeps the sequencer parked on the same row.

The control word contents and the data path are outside this block.

Top module: `uaddr_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `sel_q` reads 00, so `uaddr` follows the opcode mapping.
- R2: With `sel_q` = 00, opcodes 0x00 through 0x0B give a `uaddr` equal to the opcode.
- R3: With `sel_q` = 00, opcodes 0x0C through 0x12 all give `uaddr` = 0x1E.
- R4: With `sel_q` = 00, opcodes 0x13 through 0x1B give a `uaddr` equal to the opcode.
- R5: With `sel_q` = 00, opcode 0x1C maps to the 8-bit value 0x80. Bit 7 of that value drives `halt_row` high, and its low five bits give `uaddr` = 0x00.
- R6: With `sel_q` = 00, every opcode from 0x1D through 0xFF gives `uaddr` = 0x00 with `halt_row` low.
- R7: With `sel_q` = 01, `uaddr` equals opcode bits 4:0.
- R8: With `sel_q` = 10, `uaddr` is the constant 31 whatever the opcode.
- R9: With `sel_q` = 11, `uaddr` repeats the value it had on the previous cycle, and opcode changes have no effect.
- R10: `sel_q` takes the value of `ns_sel` at each rising clock edge, so a select change reaches `uaddr` one cycle later.
- R11: `halt_row` is low whenever `sel_q` is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 8 | Instruction register value |
| ns_sel | input | 2 | Next-source field from the current control word |
| uaddr | output | 5 | Control-store address for this cycle |
| sel_q | output | 2 | Registered next-source select |
| halt_row | output | 1 | Mapping output carries the halt marker |

## Verification
The hardest case to reach is the hold source. Its result depends on the address the sequencer produced one cycle earlier, not on any input applied at the same time. The stimulus first parks the sequencer on a mapped row. It then switches the select to hold while the opcode stays put, and only afterwards changes the opcode, so the check can see that the address stays fixed over more than one cycle. Releasing the hold then confirms that the new opcode is picked up.

// File: rtl/uaddr_seq.sv
module uaddr_seq #(
  parameter int AW = 5,
  parameter int OPW = 8,
  parameter logic [AW-1:0] SHARED_ROW = 5'h1E
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  input  logic [1:0]     ns_sel,
  output logic [AW-1:0]  uaddr,
  output logic [1:0]     sel_q,
  output logic           halt_row
);

  localparam logic [AW-1:0] FIXED_ROW = AW'((1 << AW) - 1);
  localparam logic [1:0] SRC_MAP = 2'd0, SRC_IR = 2'd1, SRC_FIX = 2'd2, SRC_HOLD = 2'd3;

  logic [AW-1:0] map_addr, addr_q;
  logic          map_halt;

  always_comb begin
    map_addr = '0;
    map_halt = 1'b0;
    if (opcode <= OPW'(8'h0B))      map_addr = opcode[AW-1:0];
    else if (opcode <= OPW'(8'h12)) map_addr = SHARED_ROW;
    else if (opcode <= OPW'(8'h1B)) map_addr = opcode[AW-1:0];
    else if (opcode == OPW'(8'h1C)) map_halt = 1'b1;
  end

  always_comb begin
    unique case (sel_q)
      SRC_MAP: uaddr = map_addr;
      SRC_IR:  uaddr = opcode[AW-1:0];
      SRC_FIX: uaddr = FIXED_ROW;
      default: uaddr = addr_q;
    endcase
  end

  assign halt_row = (sel_q == SRC_MAP) && map_halt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= SRC_MAP;
      addr_q <= '0;
    end else begin
      sel_q  <= ns_sel;
      addr_q <= uaddr;
    end
  end

  p_reset_sel_r1: assert property (@(posedge clk) !rst_n |=> sel_q == SRC_MAP);
  p_sel_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> sel_q == $past(ns_sel));
  p_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SRC_MAP && opcode >= OPW'(8'h0C) && opcode <= OPW'(8'h12)) |-> uaddr == SHARED_ROW);
  p_ir_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q == SRC_IR |-> uaddr == opcode[AW-1:0]);
  p_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q == SRC_FIX |-> uaddr == FIXED_ROW);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && sel_q == SRC_HOLD) |-> uaddr == $past(uaddr));
  p_halt_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halt_row |-> sel_q == SRC_MAP);
  p_halt_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_row |-> (opcode == OPW'(8'h1C) && uaddr == '0));

endmodule

// File: tb/uaddr_seq_tb_top.sv
`timescale 1ns/1ps
module uaddr_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] opcode = 8'h0E;
  logic [1:0] ns_sel = 2'd0;
  logic [4:0] uaddr;
  logic [1:0] sel_q;
  logic halt_row;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uaddr_seq dut_i (.clk(clk), .rst_n(rst_n), .opcode(opcode), .ns_sel(ns_sel),
                   .uaddr(uaddr), .sel_q(sel_q), .halt_row(halt_row));

  // {req[3:0], sel[1:0], opcode[7:0], exp_addr[4:0], exp_halt}
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {4'd2,  2'd0, 8'h00, 5'h00, 1'b0},  // R2
    {4'd2,  2'd0, 8'h07, 5'h07, 1'b0},  // R2
    {4'd2,  2'd0, 8'h0B, 5'h0B, 1'b0},  // R2
    {4'd3,  2'd0, 8'h0C, 5'h1E, 1'b0},  // R3
    {4'd3,  2'd0, 8'h0F, 5'h1E, 1'b0},  // R3
    {4'd3,  2'd0, 8'h12, 5'h1E, 1'b0},  // R3
    {4'd4,  2'd0, 8'h13, 5'h13, 1'b0},  // R4
    {4'd4,  2'd0, 8'h17, 5'h17, 1'b0},  // R4
    {4'd4,  2'd0, 8'h1B, 5'h1B, 1'b0},  // R4
    {4'd5,  2'd0, 8'h1C, 5'h00, 1'b1},  // R5
    {4'd6,  2'd0, 8'h1D, 5'h00, 1'b0},  // R6
    {4'd6,  2'd0, 8'hFF, 5'h00, 1'b0},  // R6
    {4'd7,  2'd1, 8'h0E, 5'h0E, 1'b0},  // R7
    {4'd7,  2'd1, 8'hA7, 5'h07, 1'b0},  // R7
    {4'd11, 2'd1, 8'h1C, 5'h1C, 1'b0},  // R11
    {4'd8,  2'd2, 8'h03, 5'h1F, 1'b0},  // R8
    {4'd11, 2'd2, 8'h1C, 5'h1F, 1'b0}   // R11
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sel in reset", sel_q, 0);
    check("R1 addr in reset", uaddr, 5'h1E);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sel after reset", sel_q, 0);
    check("R1 addr after reset", uaddr, 5'h1E);

    for (int i = 0; i < NV; i++) begin
      ns_sel = VEC[i][15:14];
      opcode = VEC[i][13:6];
      @(negedge clk);
      check($sformatf("R%0d addr v%0d", VEC[i][19:16], i), uaddr, VEC[i][5:1]);
      check($sformatf("R%0d halt v%0d", VEC[i][19:16], i), halt_row, VEC[i][0]);
      check($sformatf("R10 sel v%0d", i), sel_q, VEC[i][15:14]);
    end

    // R9: park on a mapped row, then hold and disturb the opcode
    ns_sel = 2'd0; opcode = 8'h05;
    @(negedge clk);
    check("R9 setup", uaddr, 5'h05);
    ns_sel = 2'd3;
    @(negedge clk);
    check("R9 hold first", uaddr, 5'h05);
    opcode = 8'h14;
    @(negedge clk);
    check("R9 hold opcode changed", uaddr, 5'h05);
    @(negedge clk);
    check("R9 hold again", uaddr, 5'h05);
    check("R11 halt low in hold", halt_row, 0);
    ns_sel = 2'd0;
    check("R10 no early effect", uaddr, 5'h05);
    @(negedge clk);
    check("R9 release", uaddr, 5'h14);

    // R9: hold of the fixed row
    ns_sel = 2'd2;
    @(negedge clk);
    ns_sel = 2'd3; opcode = 8'h02;
    @(negedge clk);
    check("R9 hold fixed row", uaddr, 5'h1F);

    // R1: reset in the middle of a hold
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset sel", sel_q, 0);
    check("R1 mid reset addr", uaddr, 5'h02);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule